// File: doc/BRIEF.md
# Configuration Bitstream Loader

This block sits on a host's memory-mapped bus and feeds a configuration bitstream, one 32-bit word at a time, to a chain of downstream FPGAs. The host first programs the length of the image in bytes while the loader is idle. It then turns the loader on, either in processor-push mode or in a mode where an external DMA engine does the writes. Every bus write to the data window places one word into an internal word FIFO. The downstream side drains that FIFO through a valid/ready word handshake.

The loader counts the bytes it hands downstream. It declares the load complete when that count reaches the programmed length. It stops streaming on any error: a fault reported by the targets, or a write that arrives while the FIFO is full. Completion and errors both raise a sticky interrupt. A control write with the enable bit clear turns the loader off, empties the FIFO and drops the interrupt. Setting enable and reset together holds the targets' configuration reset line high, and a later write of zero releases it, which gives a reset pulse.

Top module: `cfgld_top`

## Requirements
- R1: The bus register map is decoded by byte address: control at 0x40, status at 0x44, FIFO capacity at 0x48, FIFO fill at 0x4C, total byte count at 0x50, current byte count at 0x54, data window at 0x3000. A read returns its data on busRdata one cycle after busRead. Control reads back bit 0 = enable, bit 1 = reset, bit 2 = DMA mode. The capacity register reads DEPTH*4 bytes (64 with defaults). After reset every register reads 0 except the capacity register.
- R2: The total byte count register takes a write only while enable is clear. A write to it while enable is set leaves the old value in place.
- R3: While loading (enable set, reset clear), a data-window write pushes busWdata into the FIFO. The fill register reports the stored amount in bytes. Data-window writes made while not loading are dropped and leave the fill at its old value.
- R4: A data-window write while loading and while the FIFO holds DEPTH words is dropped and sets status bit 2 (overflow). This raises the interrupt and stops streaming.
- R5: While loading with no error and no completion, cfgValid is high whenever the FIFO is not empty. cfgWord presents the words in the order they were written. A word is consumed on each clock where cfgValid and cfgReady are both high, and the current byte count then rises by 4.
- R6: When a consumed word brings the current byte count equal to the total, status bit 18 (done) and the interrupt are set, and cfgValid stays low afterwards. The total is a nonzero multiple of 4.
- R7: A high cfgFault sampled while loading sets status bit 1 (target fault) and the interrupt, and streaming stops.
- R8: A control write with bit 0 clear clears enable and the interrupt and empties the FIFO. The done and error status bits keep their values until the next enable.
- R9: dmaReq is high exactly when loading in DMA mode, with no error and no completion, with at least DEPTH/2 words free, and with the current byte count plus the bytes held in the FIFO below the total. dmaReq is low in processor-push mode.
- R10: cfgRst is high while control holds enable and reset together. No data is accepted or streamed during that time.
- R11: A control write that sets enable while the loader is off clears the current byte count and status bits 18, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 14 | Byte address of the bus access |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRead |
| cfgWord | output | 32 | Word offered to the targets |
| cfgValid | output | 1 | cfgWord is valid |
| cfgReady | input | 1 | Targets take cfgWord this cycle |
| cfgFault | input | 1 | Targets report a configuration error |
| cfgRst | output | 1 | Configuration reset to the targets |
| dmaReq | output | 1 | Request for another DMA burst |
| irq | output | 1 | Load finished or failed |

## Verification
Register and FIFO effects of a bus write show up after the clock edge that takes the write. The combinational outputs cfgValid, cfgWord and dmaReq are therefore sampled at the falling edge that follows that clock edge. Register reads take one more edge, so the bench raises busRead at a falling edge and samples busRdata at the next one. During streaming each consumed word advances the head and the byte count at the same rising edge. The bench compares the word order at each falling edge before the pop, and it checks done and irq on the falling edge right after the last word is taken.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifo_cmd_t;

  localparam int unsigned OFS_CTRL  = 32'h0040;
  localparam int unsigned OFS_STAT  = 32'h0044;
  localparam int unsigned OFS_CAP   = 32'h0048;
  localparam int unsigned OFS_FILL  = 32'h004C;
  localparam int unsigned OFS_TOTAL = 32'h0050;
  localparam int unsigned OFS_CUR   = 32'h0054;
  localparam int unsigned OFS_WIN   = 32'h3000;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_RST_BIT   = 1;
  localparam int CTRL_DMA_BIT   = 2;
  localparam int STAT_FAULT_BIT = 1;
  localparam int STAT_OVF_BIT   = 2;
  localparam int STAT_DONE_BIT  = 18;

endpackage

// File: rtl/cfgld_fifo.sv
module cfgld_fifo
  import cfgld_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_cmd_t        cmd,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  wire doPush = cmd.push && !full;
  wire doPop  = cmd.pop && !empty;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !cmd.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: fill level never exceeds capacity
  a_r3_fill_in_range: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R4: control never pushes into a full FIFO
  a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.push && full));

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int BCNT_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] headData,
  output fifo_cmd_t         fifoCmd,
  output logic [DATA_W-1:0] pushData,
  input  logic              cfgReady,
  input  logic              cfgFault,
  output logic              cfgValid,
  output logic [DATA_W-1:0] cfgWord,
  output logic              cfgRst,
  output logic              dmaReq,
  output logic              irq
);

  localparam logic [BCNT_W-1:0] WORD_BYTES = BCNT_W'(4);
  localparam logic [CNT_W-1:0]  HALF_WORDS = CNT_W'(DEPTH / 2);

  logic ctrlEn, ctrlRst, ctrlDma;
  logic doneFlag, faultFlag, ovfFlag;
  logic [BCNT_W-1:0] totalCount, curCount;

  wire selCtrl  = (busAddr == ADDR_W'(OFS_CTRL));
  wire selTotal = (busAddr == ADDR_W'(OFS_TOTAL));
  wire selWin   = (busAddr == ADDR_W'(OFS_WIN));

  wire wrCtrl     = busWrite && selCtrl;
  wire wrTotal    = busWrite && selTotal;
  wire wrData     = busWrite && selWin;
  wire ctrlOff    = wrCtrl && !busWdata[CTRL_EN_BIT];
  wire enableRise = wrCtrl && busWdata[CTRL_EN_BIT] && !ctrlEn;

  wire loading = ctrlEn && !ctrlRst;
  wire errAny  = faultFlag || ovfFlag;
  wire halted  = doneFlag || errAny;

  wire pushOk  = wrData && loading && !fifoFull;
  wire ovfHit  = wrData && loading && fifoFull;
  wire faultHit = loading && cfgFault;

  assign cfgValid = loading && !fifoEmpty && !halted;
  assign cfgWord  = headData;
  wire pop        = cfgValid && cfgReady;
  wire lastWord   = pop && ((curCount + WORD_BYTES) == totalCount);

  assign fifoCmd.push  = pushOk;
  assign fifoCmd.pop   = pop;
  assign fifoCmd.flush = ctrlOff;
  assign pushData      = busWdata;

  assign cfgRst = ctrlEn && ctrlRst;

  wire [BCNT_W-1:0] fillBytes = BCNT_W'(fifoCount) << 2;
  wire [BCNT_W-1:0] inFlight  = curCount + fillBytes;
  wire [CNT_W-1:0]  freeWords = CNT_W'(DEPTH) - fifoCount;

  assign dmaReq = loading && ctrlDma && !halted &&
                  (freeWords >= HALF_WORDS) && (inFlight < totalCount);

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      ctrlRst <= 1'b0;
      ctrlDma <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn  <= busWdata[CTRL_EN_BIT];
      ctrlRst <= busWdata[CTRL_RST_BIT];
      ctrlDma <= busWdata[CTRL_DMA_BIT];
    end
  end

  // total byte count, locked while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   totalCount <= '0;
    else if (wrTotal && !ctrlEn) totalCount <= busWdata[BCNT_W-1:0];
  end

  // progress counter and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount  <= '0;
      doneFlag  <= 1'b0;
      faultFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else if (enableRise) begin
      curCount  <= '0;
      doneFlag  <= 1'b0;
      faultFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (pop)      curCount  <= curCount + WORD_BYTES;
      if (lastWord) doneFlag  <= 1'b1;
      if (faultHit) faultFlag <= 1'b1;
      if (ovfHit)   ovfFlag   <= 1'b1;
    end
  end

  // interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              irq <= 1'b0;
    else if (ctrlOff)                       irq <= 1'b0;
    else if (lastWord || faultHit || ovfHit) irq <= 1'b1;
  end

  // registered read port
  logic [DATA_W-1:0] statWord, rdNext;
  always_comb begin
    statWord = '0;
    statWord[STAT_FAULT_BIT] = faultFlag;
    statWord[STAT_OVF_BIT]   = ovfFlag;
    statWord[STAT_DONE_BIT]  = doneFlag;
  end

  always_comb begin
    rdNext = '0;
    case (busAddr)
      ADDR_W'(OFS_CTRL):  rdNext = DATA_W'({ctrlDma, ctrlRst, ctrlEn});
      ADDR_W'(OFS_STAT):  rdNext = statWord;
      ADDR_W'(OFS_CAP):   rdNext = DATA_W'(DEPTH * 4);
      ADDR_W'(OFS_FILL):  rdNext = DATA_W'(fillBytes);
      ADDR_W'(OFS_TOTAL): rdNext = DATA_W'(totalCount);
      ADDR_W'(OFS_CUR):   rdNext = DATA_W'(curCount);
      default:            rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busRdata <= '0;
    else if (busRead) busRdata <= rdNext;
  end

  // R2: total is frozen while enabled
  a_r2_total_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrTotal && ctrlEn) |=> $stable(totalCount));

  // R6: completion always comes with the interrupt
  a_r6_irq_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> irq);

  // R8: switching off drops the interrupt and empties the FIFO
  a_r8_off_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOff |=> (!irq && fifoEmpty));

  // R9: a burst request implies room for half the FIFO
  a_r9_dma_room: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (fifoCount <= HALF_WORDS));

  // R10: nothing streams while the target reset is held
  a_r10_rst_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgRst |-> !cfgValid);

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int BCNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] cfgWord,
  output logic              cfgValid,
  input  logic              cfgReady,
  input  logic              cfgFault,
  output logic              cfgRst,
  output logic              dmaReq,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  fifo_cmd_t         fifoCmd;
  logic [DATA_W-1:0] pushData, headData;
  logic [CNT_W-1:0]  fifoCount;
  logic              fifoFull, fifoEmpty;

  cfgld_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BCNT_W(BCNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busWdata(busWdata), .busRdata(busRdata),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .headData(headData), .fifoCmd(fifoCmd), .pushData(pushData),
    .cfgReady(cfgReady), .cfgFault(cfgFault), .cfgValid(cfgValid),
    .cfgWord(cfgWord), .cfgRst(cfgRst), .dmaReq(dmaReq), .irq(irq)
  );

  cfgld_fifo #(
    .WIDTH(DATA_W), .DEPTH(DEPTH)
  ) fifo_i (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd), .pushData(pushData),
    .headData(headData), .count(fifoCount), .full(fifoFull), .empty(fifoEmpty)
  );

endmodule

// File: tb/cfgld_top_tb_top.sv
module cfgld_top_tb_top;

  localparam logic [13:0] A_CTRL  = 14'h0040;
  localparam logic [13:0] A_STAT  = 14'h0044;
  localparam logic [13:0] A_CAP   = 14'h0048;
  localparam logic [13:0] A_FILL  = 14'h004C;
  localparam logic [13:0] A_TOTAL = 14'h0050;
  localparam logic [13:0] A_CUR   = 14'h0054;
  localparam logic [13:0] A_WIN   = 14'h3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [13:0] busAddr = '0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, cfgWord;
  logic cfgValid, cfgRst, dmaReq, irq;
  logic cfgReady = 1'b0, cfgFault = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfgld_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .cfgWord(cfgWord), .cfgValid(cfgValid), .cfgReady(cfgReady),
    .cfgFault(cfgFault), .cfgRst(cfgRst), .dmaReq(dmaReq), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  task automatic rdCheck(input string req, input logic [13:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    check("R1 dmaReq after reset", {31'b0, dmaReq}, 32'd0);
    check("R1 cfgValid after reset", {31'b0, cfgValid}, 32'd0);
    rdCheck("R1 control after reset", A_CTRL, 32'd0);
    rdCheck("R1 capacity register", A_CAP, 32'd64);
    rdCheck("R1 fill after reset", A_FILL, 32'd0);
    rdCheck("R1 status after reset", A_STAT, 32'd0);
  endtask

  task automatic testTotalLock();
    busWr(A_TOTAL, 32'd16);
    rdCheck("R2 total written while off", A_TOTAL, 32'd16);
    busWr(A_CTRL, 32'd1);
    rdCheck("R1 control readback", A_CTRL, 32'd1);
    busWr(A_TOTAL, 32'd100);
    rdCheck("R2 total locked while on", A_TOTAL, 32'd16);
  endtask

  task automatic testStream();
    logic [31:0] words [4];
    for (int i = 0; i < 4; i++) words[i] = 32'hA5A50000 + 32'(i * 17);
    for (int i = 0; i < 4; i++) busWr(A_WIN, words[i]);
    rdCheck("R3 fill in bytes", A_FILL, 32'd16);
    check("R5 valid with data", {31'b0, cfgValid}, 32'd1);
    cfgReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R5 word order", cfgWord, words[i]);
      @(negedge clk);
    end
    cfgReady = 1'b0;
    check("R6 irq at completion", {31'b0, irq}, 32'd1);
    check("R6 valid drops at completion", {31'b0, cfgValid}, 32'd0);
    rdCheck("R5 current count", A_CUR, 32'd16);
    rdCheck("R6 done bit", A_STAT, 32'h0004_0000);
    busWr(A_WIN, 32'hDEAD0001);
    check("R6 no stream after done", {31'b0, cfgValid}, 32'd0);
    rdCheck("R3 fill after late push", A_FILL, 32'd4);
  endtask

  task automatic testOff();
    busWr(A_CTRL, 32'd0);
    check("R8 irq cleared", {31'b0, irq}, 32'd0);
    rdCheck("R8 FIFO emptied", A_FILL, 32'd0);
    rdCheck("R8 done kept while off", A_STAT, 32'h0004_0000);
    busWr(A_WIN, 32'h12345678);
    rdCheck("R3 write dropped while off", A_FILL, 32'd0);
  endtask

  task automatic testReenable();
    busWr(A_CTRL, 32'd1);
    rdCheck("R11 status cleared", A_STAT, 32'd0);
    rdCheck("R11 current count cleared", A_CUR, 32'd0);
    busWr(A_CTRL, 32'd0);
  endtask

  task automatic testOverflow();
    busWr(A_TOTAL, 32'd1000);
    busWr(A_CTRL, 32'd1);
    for (int i = 0; i < 16; i++) busWr(A_WIN, 32'(i));
    rdCheck("R4 fill at capacity", A_FILL, 32'd64);
    check("R4 no irq before overflow", {31'b0, irq}, 32'd0);
    busWr(A_WIN, 32'hFFFF0000);
    check("R4 irq on overflow", {31'b0, irq}, 32'd1);
    check("R4 streaming stops", {31'b0, cfgValid}, 32'd0);
    rdCheck("R4 overflow bit", A_STAT, 32'd4);
    rdCheck("R4 fill unchanged", A_FILL, 32'd64);
    busWr(A_CTRL, 32'd0);
  endtask

  task automatic testFault();
    busWr(A_CTRL, 32'd1);
    busWr(A_WIN, 32'h0BAD0BAD);
    check("R7 valid before fault", {31'b0, cfgValid}, 32'd1);
    @(negedge clk); cfgFault = 1'b1;
    @(negedge clk); cfgFault = 1'b0;
    check("R7 irq on fault", {31'b0, irq}, 32'd1);
    check("R7 streaming stops", {31'b0, cfgValid}, 32'd0);
    rdCheck("R7 fault bit", A_STAT, 32'd2);
    busWr(A_CTRL, 32'd0);
  endtask

  task automatic testDma();
    busWr(A_TOTAL, 32'd32);
    busWr(A_CTRL, 32'd5);
    check("R9 request when empty", {31'b0, dmaReq}, 32'd1);
    for (int i = 0; i < 7; i++) busWr(A_WIN, 32'(i));
    check("R9 request with bytes left", {31'b0, dmaReq}, 32'd1);
    busWr(A_WIN, 32'd7);
    check("R9 no request when all bytes queued", {31'b0, dmaReq}, 32'd0);
    busWr(A_CTRL, 32'd0);
    busWr(A_TOTAL, 32'd128);
    busWr(A_CTRL, 32'd5);
    for (int i = 0; i < 8; i++) busWr(A_WIN, 32'(i));
    check("R9 request at half full", {31'b0, dmaReq}, 32'd1);
    busWr(A_WIN, 32'd8);
    check("R9 no request past half", {31'b0, dmaReq}, 32'd0);
    busWr(A_CTRL, 32'd0);
    busWr(A_CTRL, 32'd1);
    check("R9 no request in push mode", {31'b0, dmaReq}, 32'd0);
    busWr(A_CTRL, 32'd0);
  endtask

  task automatic testTargetReset();
    busWr(A_CTRL, 32'd3);
    check("R10 reset line high", {31'b0, cfgRst}, 32'd1);
    busWr(A_WIN, 32'h55AA55AA);
    check("R10 no stream during reset", {31'b0, cfgValid}, 32'd0);
    rdCheck("R10 write dropped during reset", A_FILL, 32'd0);
    busWr(A_CTRL, 32'd0);
    check("R10 reset line released", {31'b0, cfgRst}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTotalLock();
    testStream();
    testOff();
    testReenable();
    testOverflow();
    testFault();
    testDma();
    testTargetReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule